// File: doc/BRIEF.md
# Programmable-Latency Burst Read Responder

This block is the device end of a synchronous read port in which address and data share one bus. When the host pulls the address strobe low on a rising clock edge while the chip is selected, the block captures the start address from the bus. It then waits for a programmable initial access latency. After that it puts one data word per clock onto the bus. The first word is flagged by a ready output.

Words come from a small internal array. Each following edge steps the address inside an aligned group of eight words, so the burst wraps inside that group. The initial latency is set through a separate write port. A new value is accepted only if it is between three and seven, and it applies from the next burst onward. The bus is split into an input half and an output half with an output-enable. The output-enable is high only while the block actually drives read data.

Top module: `burst_rd_resp`

## Requirements
- R1: After reset the initial latency is 4, and `rdy` and `bus_oe` are low.
- R2: A write on the configuration port with a value from 3 to 7 replaces the latency. A written value of 0, 1 or 2 is dropped and the latency in force stays unchanged.
- R3: The start address is captured on an edge where `avd_n` and `cs_n` are both low. With latency L, `rdy` and the first word appear right after the L-th rising edge that follows the capturing edge. Before that, `rdy` and `bus_oe` stay low.
- R4: `rdy` rises together with the first valid word, so the word can be taken in the first cycle in which `rdy` is high.
- R5: Each rising edge after the first word moves to the next word. The low 3 address bits count up modulo 8 and the upper bits are kept, so a start at offset 6 reads 6, 7, 0, 1, and so on.
- R6: The word at address a is {4'hC, a[5:0], ~a[5:0]} XOR a[15:6], with a[15:6] zero-extended to 16 bits.
- R7: `bus_oe` is high only while a burst is delivering data with `cs_n` and `oe_n` both low, and `bus_out` is zero whenever `bus_oe` is low. With `oe_n` high, the burst keeps advancing and `rdy` stays high.
- R8: Raising `cs_n` aborts the burst at once: `bus_oe` and `rdy` drop in that same cycle. No data returns after `cs_n` goes low again until a new address is captured.
- R9: An address strobe during the wait or data phase restarts the full latency count from the new address.
- R10: A latency write made while a burst is waiting does not change that burst. It takes effect from the next captured address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Latency register write strobe |
| cfg_lat | input | 3 | Latency value to write (3 to 7 accepted) |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable request, active low |
| avd_n | input | 1 | Address strobe, active low, sampled on rising edge |
| bus_in | input | 16 | Shared bus as seen by the block (address during capture) |
| bus_out | output | 16 | Read data driven onto the shared bus |
| bus_oe | output | 1 | High while the block drives the shared bus |
| rdy | output | 1 | High while valid burst data is present |

## Verification
Every latency from 3 to 7 is combined with every start offset in the 8-word group. This separates an off-by-one in the wait count from an error in the wrap arithmetic, and the varying upper address bits expose any loss of the page part of the word. Back-to-back strobes without deselection test restart against continued streaming. Rejected configuration values and a write made during the wait phase show whether the latency register filters its inputs and whether a burst in flight keeps its count. Pulses on `oe_n` and `cs_n` tell a bus that only tristates apart from a burst that is really aborted.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned IW = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DATA
  } seq_state_e;

  function automatic logic [DW-1:0] word_of(input logic [IW-1:0] idx);
    return {4'hC, idx, ~idx};
  endfunction
endpackage

// File: rtl/burst_lat_cfg.sv
module burst_lat_cfg #(
  parameter int unsigned LW      = 3,
  parameter int unsigned LAT_MIN = 3,
  parameter int unsigned LAT_MAX = 7,
  parameter int unsigned LAT_DEF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_val,
  output logic [LW-1:0] lat_q
);
  logic          in_range;
  logic          lat_en;
  logic [LW-1:0] lat_d;

  always_comb begin
    in_range = (wr_val >= LW'(LAT_MIN)) && (wr_val <= LW'(LAT_MAX));
    lat_en   = wr_en && in_range;
    lat_d    = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= LW'(LAT_DEF);
    else if (lat_en) lat_q <= lat_d;
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_rd_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned LW     = 3,
  parameter int unsigned WRAP_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          avd_n,
  input  logic [AW-1:0] addr_in,
  input  logic [LW-1:0] lat,
  output logic          in_data,
  output logic [AW-1:0] addr_q
);
  seq_state_e    st_q, st_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] addr_d;
  logic          capture;

  always_comb begin
    capture = !avd_n && !cs_n;
    st_d    = st_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    if (cs_n) begin
      st_d = ST_IDLE;
    end else if (capture) begin
      st_d   = ST_WAIT;
      cnt_d  = lat - LW'(1);
      addr_d = addr_in;
    end else begin
      unique case (st_q)
        ST_WAIT: begin
          if (cnt_q == '0) st_d  = ST_DATA;
          else             cnt_d = cnt_q - LW'(1);
        end
        ST_DATA: addr_d = {addr_q[AW-1:WRAP_W], addr_q[WRAP_W-1:0] + WRAP_W'(1)};
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
    end
  end

  assign in_data = (st_q == ST_DATA);
endmodule

// File: rtl/burst_word_rom.sv
module burst_word_rom
  import burst_rd_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic [IW-1:0] idx,
  output logic [DW-1:0] word
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign mem[g] = word_of(IW'(g));
  end

  assign word = mem[idx];
endmodule

// File: rtl/burst_rd_resp.sv
module burst_rd_resp
  import burst_rd_pkg::*;
#(
  parameter int unsigned LW      = 3,
  parameter int unsigned LAT_MIN = 3,
  parameter int unsigned LAT_MAX = 7,
  parameter int unsigned LAT_DEF = 4,
  parameter int unsigned WRAP_W  = 3,
  parameter int unsigned DEPTH   = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [LW-1:0] cfg_lat,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          avd_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          rdy
);
  localparam int unsigned AW = DW;
  localparam int unsigned PW = AW - IW;

  logic          rst_s1, rst_s;
  logic [LW-1:0] lat_q;
  logic [AW-1:0] addr_q;
  logic          in_data;
  logic [DW-1:0] arr_word;
  logic [DW-1:0] page_mix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s  <= rst_s1;
    end
  end

  burst_lat_cfg #(
    .LW(LW), .LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX), .LAT_DEF(LAT_DEF)
  ) u_cfg (
    .clk(clk), .rst_n(rst_s), .wr_en(cfg_we), .wr_val(cfg_lat), .lat_q(lat_q)
  );

  burst_seq #(
    .AW(AW), .LW(LW), .WRAP_W(WRAP_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_s), .cs_n(cs_n), .avd_n(avd_n), .addr_in(bus_in),
    .lat(lat_q), .in_data(in_data), .addr_q(addr_q)
  );

  burst_word_rom #(.DEPTH(DEPTH)) u_rom (
    .idx(addr_q[IW-1:0]), .word(arr_word)
  );

  always_comb begin
    page_mix = DW'(addr_q[AW-1:IW]);
    rdy      = in_data && !cs_n;
    bus_oe   = rdy && !oe_n;
    bus_out  = bus_oe ? (arr_word ^ page_mix) : '0;
  end

  logic unused_pw;
  assign unused_pw = (PW == 0);
endmodule

// File: rtl/burst_rd_resp_chk.sv
module burst_rd_resp_chk #(
  parameter int unsigned AW      = 16,
  parameter int unsigned LW      = 3,
  parameter int unsigned LAT_MIN = 3,
  parameter int unsigned LAT_MAX = 7,
  parameter int unsigned WRAP_W  = 3
) (
  input logic          clk,
  input logic          rst_s,
  input logic          cs_n,
  input logic          oe_n,
  input logic          avd_n,
  input logic          bus_oe,
  input logic          rdy,
  input logic [LW-1:0] lat_q,
  input logic [AW-1:0] addr_q
);
  assert_lat_range_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (lat_q >= LW'(LAT_MIN)) && (lat_q <= LW'(LAT_MAX)));

  assert_oe_gated_R7: assert property (@(posedge clk) disable iff (!rst_s)
    bus_oe |-> (rdy && !oe_n));

  assert_cs_abort_R8: assert property (@(posedge clk) disable iff (!rst_s)
    cs_n |-> (!rdy && !bus_oe));

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (!avd_n && !cs_n) |=> !rdy);

  assert_wrap_step_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (rdy && $past(rdy)) |->
      (addr_q[WRAP_W-1:0] == WRAP_W'($past(addr_q[WRAP_W-1:0]) + WRAP_W'(1))));

  assert_page_hold_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (rdy && $past(rdy)) |-> $stable(addr_q[AW-1:WRAP_W]));
endmodule

bind burst_rd_resp burst_rd_resp_chk #(
  .AW(16), .LW(LW), .LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX), .WRAP_W(WRAP_W)
) u_chk (
  .clk(clk), .rst_s(rst_s), .cs_n(cs_n), .oe_n(oe_n), .avd_n(avd_n),
  .bus_oe(bus_oe), .rdy(rdy), .lat_q(lat_q), .addr_q(addr_q)
);

// File: tb/burst_rd_resp_tb.sv
module burst_rd_resp_tb;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_lat;
  logic        cs_n;
  logic        oe_n;
  logic        avd_n;
  logic [15:0] bus_in;
  logic [15:0] bus_out;
  logic        bus_oe;
  logic        rdy;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int lat_m  = 4;

  burst_rd_resp u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lat(cfg_lat),
    .cs_n(cs_n), .oe_n(oe_n), .avd_n(avd_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .rdy(rdy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [15:0] exp_word(input logic [15:0] a);
    return {4'hC, a[5:0], ~a[5:0]} ^ {6'b0, a[15:6]};
  endfunction

  function automatic logic [15:0] step(input logic [15:0] a, input int k);
    return {a[15:3], 3'(a[2:0] + 3'(k))};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      summary();
    end
  end

  task automatic cfg_write(input logic [2:0] v);
    @(negedge clk);
    cfg_we  = 1'b1;
    cfg_lat = v;
    @(negedge clk);
    cfg_we  = 1'b0;
    if (v >= 3) lat_m = int'(v);
  endtask

  // R3/R4/R5/R6/R9: capture, wait L edges, then stream nw words
  task automatic run_burst(input int lat, input logic [15:0] a, input int nw,
                           input logic [2:0] cfg_mid);
    @(negedge clk);
    cs_n   = 1'b0;
    avd_n  = 1'b0;
    bus_in = a;
    @(negedge clk);
    avd_n  = 1'b1;
    bus_in = 16'h0;
    check("R9 rdy low after capture", 32'(rdy), 32'd0);
    if (cfg_mid != 0) begin
      cfg_we  = 1'b1;
      cfg_lat = cfg_mid;
    end
    for (int k = 1; k < lat; k++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      check("R3 rdy low during wait", 32'(rdy), 32'd0);
      check("R3 bus idle during wait", 32'(bus_oe), 32'd0);
    end
    if (cfg_mid >= 3) lat_m = int'(cfg_mid);
    @(negedge clk);
    check("R4 rdy with first word", 32'(rdy), 32'd1);
    check("R3 bus driven at latency", 32'(bus_oe), 32'd1);
    check("R6 first word", 32'(bus_out), 32'(exp_word(a)));
    for (int w = 1; w < nw; w++) begin
      @(negedge clk);
      check("R5 wrapped word", 32'(bus_out), 32'(exp_word(step(a, w))));
    end
  endtask

  // R8: deselect aborts and nothing resumes without a new strobe
  task automatic end_burst();
    @(negedge clk);
    cs_n = 1'b1;
    #1;
    check("R8 bus off on deselect", 32'(bus_oe), 32'd0);
    check("R8 rdy off on deselect", 32'(rdy), 32'd0);
    @(negedge clk);
    cs_n = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R8 no resume", 32'(rdy), 32'd0);
    end
  endtask

  initial begin
    rst_n   = 1'b0;
    cfg_we  = 1'b0;
    cfg_lat = 3'd0;
    cs_n    = 1'b1;
    oe_n    = 1'b0;
    avd_n   = 1'b1;
    bus_in  = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 rdy at reset", 32'(rdy), 32'd0);
    check("R1 bus_oe at reset", 32'(bus_oe), 32'd0);

    // R1: default latency of 4
    run_burst(4, 16'h0123, 4, 3'd0);
    end_burst();

    // sweep every latency and every start offset, back to back (R9)
    for (int l = 3; l <= 7; l++) begin
      cfg_write(3'(l));
      for (int off = 0; off < 8; off++) begin
        logic [15:0] a;
        a = (16'(l * 1177 + off * 4099) & 16'hFFF8) | 16'(off);
        run_burst(lat_m, a, 10, 3'd0);
      end
      end_burst();
    end

    // R2: rejected values keep the previous latency
    cfg_write(3'd5);
    cfg_write(3'd2);
    cfg_write(3'd0);
    cfg_write(3'd1);
    check("R2 model latency kept", 32'(lat_m), 32'd5);
    run_burst(lat_m, 16'hA5E6, 9, 3'd0);

    // R10: write during wait does not alter that burst
    run_burst(5, 16'h3C41, 4, 3'd7);
    run_burst(7, 16'h0F07, 4, 3'd0);

    // R7: oe_n high tristates while the burst keeps advancing
    run_burst(7, 16'h8002, 3, 3'd0);
    @(negedge clk);
    oe_n = 1'b1;
    #1;
    check("R7 bus off with oe_n high", 32'(bus_oe), 32'd0);
    check("R7 bus_out zero when off", 32'(bus_out), 32'd0);
    check("R7 rdy stays high", 32'(rdy), 32'd1);
    @(negedge clk);
    @(negedge clk);
    oe_n = 1'b0;
    #1;
    check("R7 burst advanced meanwhile", 32'(bus_out), 32'(exp_word(step(16'h8002, 5))));
    end_burst();

    summary();
  end
endmodule